// File: doc/BRIEF.md
# Instruction Dispatch Steering Unit

This unit sits between rename and the issue/memory queues of an out-of-order core. Each cycle it receives a group of up to `SLOTS` renamed instructions. Each slot carries a valid bit and type flags for squashed, load, store, non-speculative and nop. The unit walks the slots from oldest to youngest and sends each one to its destination. Loads and stores go to the load/store queue and also take an instruction-queue entry. Non-speculative instructions use a dedicated insert port. Nops are marked complete and only advance the instruction-queue tail. Ordinary instructions are written into the instruction queue. Squashed instructions are dropped.

The instruction queue is represented only by its free-entry count, `iq_free_i`. Every instruction the unit accepts, other than a squashed one, takes one entry. If a slot finds no free entry, the unit stops partway through the group and raises `block_o` for the stall controller. `consumed_o` reports how many leading slots were handled, so the remainder can be held in a skid buffer. All strobes are combinational within the cycle. Event counters update on the next clock edge.

Top module: `disp_steer`

## Requirements
- R1: Slots are handled in order from slot 0, the oldest, upward, and bit i of every per-slot bus belongs to slot i. Only the slots below the first slot with `slot_valid_i` low are considered. Any valid slot above that gap raises no strobe and is not counted in `consumed_o`.
- R2: A squashed slot raises no strobe and is counted in `consumed_o`. It takes no queue entry and adds one to `sq_cnt_o` at the next edge. The squashed flag outranks every other flag and also outranks a full queue.
- R3: Every accepted slot that is not squashed takes one instruction-queue entry. Suppose a valid, non-squashed slot is reached when the number of entries already taken this cycle equals `iq_free_i`. Then `block_o` is 1 for that cycle, that slot and every later slot raise no strobe, and `full_cnt_o` rises by one at the next edge.
- R4: A slot with the load flag raises both `lsq_ld_o` and `iq_wr_o`. The load flag outranks the store, non-speculative and nop flags. `ld_cnt_o` counts each such slot.
- R5: A slot with the store flag and no load flag raises both `lsq_st_o` and `iq_wr_o`. `st_cnt_o` counts each such slot.
- R6: A slot with the non-speculative flag and neither memory flag raises `ns_wr_o` and `mark_commit_o`, and does not raise `iq_wr_o`. `ns_cnt_o` counts each such slot.
- R7: A slot whose only flag is nop raises `tail_adv_o`, `mark_issued_o`, `mark_exec_o` and `mark_commit_o`, and does not raise `iq_wr_o`.
- R8: An accepted slot with no flags raises `iq_wr_o` only, and `disp_cnt_o` counts it.
- R9: `consumed_o` equals the number of leading slots that were either dropped or accepted in the cycle.
- R10: While `rst_ni` is low, all six counters read zero. The counters wrap at 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_valid_i | input | SLOTS | Slot holds an instruction |
| slot_squash_i | input | SLOTS | Instruction is squashed |
| slot_load_i | input | SLOTS | Instruction is a load |
| slot_store_i | input | SLOTS | Instruction is a store |
| slot_nspec_i | input | SLOTS | Instruction is non-speculative |
| slot_nop_i | input | SLOTS | Instruction is a nop |
| iq_free_i | input | FREE_W | Free instruction-queue entries |
| iq_wr_o | output | SLOTS | Instruction-queue insert strobe |
| lsq_ld_o | output | SLOTS | Load-queue insert strobe |
| lsq_st_o | output | SLOTS | Store-queue insert strobe |
| ns_wr_o | output | SLOTS | Non-speculative insert strobe |
| tail_adv_o | output | SLOTS | Instruction-queue tail advance, nop only |
| mark_issued_o | output | SLOTS | Mark instruction issued |
| mark_exec_o | output | SLOTS | Mark instruction executed |
| mark_commit_o | output | SLOTS | Mark instruction commit-ready |
| consumed_o | output | $clog2(SLOTS+1) | Leading slots handled this cycle |
| block_o | output | 1 | Queue full: block and stall upstream |
| sq_cnt_o | output | CNT_W | Squashed slots dropped |
| full_cnt_o | output | CNT_W | Queue-full stall events |
| ld_cnt_o | output | CNT_W | Loads dispatched |
| st_cnt_o | output | CNT_W | Stores dispatched |
| ns_cnt_o | output | CNT_W | Non-speculative instructions dispatched |
| disp_cnt_o | output | CNT_W | Ordinary instructions dispatched |

## Verification
The assertions assume that `iq_free_i` is stable and known while the flags are being sampled. They also assume that the free count only bounds the group and does not change in response to the strobes of the same cycle. The stimulus changes inputs only at the falling clock edge. It holds free counts between 0 and 7, which covers a queue that is already full, one that fills partway through the group and one with room for the whole group. It sets several type flags on one slot at once, so that the priority order is what decides the result.

// File: rtl/disp_pkg.sv
package disp_pkg;
  typedef enum logic [2:0] {
    K_DROP,
    K_LOAD,
    K_STORE,
    K_NSPEC,
    K_NOP,
    K_PLAIN
  } kind_e;
endpackage

// File: rtl/disp_classify.sv
module disp_classify
  import disp_pkg::*;
(
  input  logic  squash_i,
  input  logic  load_i,
  input  logic  store_i,
  input  logic  nspec_i,
  input  logic  nop_i,
  output kind_e kind_o
);
  // fixed priority: squash > load > store > nspec > nop > plain
  always_comb begin
    if (squash_i)      kind_o = K_DROP;
    else if (load_i)   kind_o = K_LOAD;
    else if (store_i)  kind_o = K_STORE;
    else if (nspec_i)  kind_o = K_NSPEC;
    else if (nop_i)    kind_o = K_NOP;
    else               kind_o = K_PLAIN;
  end
endmodule

// File: rtl/disp_scan.sv
module disp_scan
  import disp_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int FREE_W = 6,
  localparam int CW    = $clog2(SLOTS + 1),
  localparam int MW    = ((FREE_W > CW) ? FREE_W : CW) + 1
) (
  input  logic [SLOTS-1:0]  valid_i,
  input  kind_e             kind_i [SLOTS],
  input  logic [FREE_W-1:0] free_i,
  output logic [SLOTS-1:0]  take_o,
  output logic [SLOTS-1:0]  drop_o,
  output logic [CW-1:0]     consumed_o,
  output logic              block_o
);
  logic          alive;
  logic [MW-1:0] used;

  // serial in-order walk; stops at first gap or first slot without an entry
  always_comb begin
    alive      = 1'b1;
    used       = '0;
    take_o     = '0;
    drop_o     = '0;
    consumed_o = '0;
    block_o    = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (alive && valid_i[i]) begin
        if (kind_i[i] == K_DROP) begin
          drop_o[i]  = 1'b1;
          consumed_o = consumed_o + CW'(1);
        end else if (used >= MW'(free_i)) begin
          block_o = 1'b1;
          alive   = 1'b0;
        end else begin
          take_o[i]  = 1'b1;
          used       = used + MW'(1);
          consumed_o = consumed_o + CW'(1);
        end
      end else begin
        alive = 1'b0;
      end
    end
  end
endmodule

// File: rtl/disp_stats.sv
module disp_stats #(
  parameter int SLOTS = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SLOTS-1:0] drop_i,
  input  logic             block_i,
  input  logic [SLOTS-1:0] ld_i,
  input  logic [SLOTS-1:0] st_i,
  input  logic [SLOTS-1:0] ns_i,
  input  logic [SLOTS-1:0] plain_i,
  output logic [CNT_W-1:0] sq_cnt_o,
  output logic [CNT_W-1:0] full_cnt_o,
  output logic [CNT_W-1:0] ld_cnt_o,
  output logic [CNT_W-1:0] st_cnt_o,
  output logic [CNT_W-1:0] ns_cnt_o,
  output logic [CNT_W-1:0] disp_cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq_cnt_o   <= '0;
      full_cnt_o <= '0;
      ld_cnt_o   <= '0;
      st_cnt_o   <= '0;
      ns_cnt_o   <= '0;
      disp_cnt_o <= '0;
    end else begin
      sq_cnt_o   <= sq_cnt_o   + CNT_W'($countones(drop_i));
      full_cnt_o <= full_cnt_o + CNT_W'(block_i);
      ld_cnt_o   <= ld_cnt_o   + CNT_W'($countones(ld_i));
      st_cnt_o   <= st_cnt_o   + CNT_W'($countones(st_i));
      ns_cnt_o   <= ns_cnt_o   + CNT_W'($countones(ns_i));
      disp_cnt_o <= disp_cnt_o + CNT_W'($countones(plain_i));
    end
  end
endmodule

// File: rtl/disp_steer.sv
module disp_steer
  import disp_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int FREE_W = 6,
  parameter int CNT_W  = 16,
  localparam int CW    = $clog2(SLOTS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SLOTS-1:0]  slot_valid_i,
  input  logic [SLOTS-1:0]  slot_squash_i,
  input  logic [SLOTS-1:0]  slot_load_i,
  input  logic [SLOTS-1:0]  slot_store_i,
  input  logic [SLOTS-1:0]  slot_nspec_i,
  input  logic [SLOTS-1:0]  slot_nop_i,
  input  logic [FREE_W-1:0] iq_free_i,
  output logic [SLOTS-1:0]  iq_wr_o,
  output logic [SLOTS-1:0]  lsq_ld_o,
  output logic [SLOTS-1:0]  lsq_st_o,
  output logic [SLOTS-1:0]  ns_wr_o,
  output logic [SLOTS-1:0]  tail_adv_o,
  output logic [SLOTS-1:0]  mark_issued_o,
  output logic [SLOTS-1:0]  mark_exec_o,
  output logic [SLOTS-1:0]  mark_commit_o,
  output logic [CW-1:0]     consumed_o,
  output logic              block_o,
  output logic [CNT_W-1:0]  sq_cnt_o,
  output logic [CNT_W-1:0]  full_cnt_o,
  output logic [CNT_W-1:0]  ld_cnt_o,
  output logic [CNT_W-1:0]  st_cnt_o,
  output logic [CNT_W-1:0]  ns_cnt_o,
  output logic [CNT_W-1:0]  disp_cnt_o
);
  kind_e            kind [SLOTS];
  logic [SLOTS-1:0] take;
  logic [SLOTS-1:0] drop;
  logic [SLOTS-1:0] plain;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    disp_classify u_cls (
      .squash_i (slot_squash_i[g]),
      .load_i   (slot_load_i[g]),
      .store_i  (slot_store_i[g]),
      .nspec_i  (slot_nspec_i[g]),
      .nop_i    (slot_nop_i[g]),
      .kind_o   (kind[g])
    );

    assign lsq_ld_o[g]      = take[g] && (kind[g] == K_LOAD);
    assign lsq_st_o[g]      = take[g] && (kind[g] == K_STORE);
    assign ns_wr_o[g]       = take[g] && (kind[g] == K_NSPEC);
    assign tail_adv_o[g]    = take[g] && (kind[g] == K_NOP);
    assign plain[g]         = take[g] && (kind[g] == K_PLAIN);
    assign iq_wr_o[g]       = lsq_ld_o[g] || lsq_st_o[g] || plain[g];
    assign mark_issued_o[g] = tail_adv_o[g];
    assign mark_exec_o[g]   = tail_adv_o[g];
    assign mark_commit_o[g] = tail_adv_o[g] || ns_wr_o[g];
  end

  disp_scan #(
    .SLOTS  (SLOTS),
    .FREE_W (FREE_W)
  ) u_scan (
    .valid_i    (slot_valid_i),
    .kind_i     (kind),
    .free_i     (iq_free_i),
    .take_o     (take),
    .drop_o     (drop),
    .consumed_o (consumed_o),
    .block_o    (block_o)
  );

  disp_stats #(
    .SLOTS (SLOTS),
    .CNT_W (CNT_W)
  ) u_stats (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .drop_i     (drop),
    .block_i    (block_o),
    .ld_i       (lsq_ld_o),
    .st_i       (lsq_st_o),
    .ns_i       (ns_wr_o),
    .plain_i    (plain),
    .sq_cnt_o   (sq_cnt_o),
    .full_cnt_o (full_cnt_o),
    .ld_cnt_o   (ld_cnt_o),
    .st_cnt_o   (st_cnt_o),
    .ns_cnt_o   (ns_cnt_o),
    .disp_cnt_o (disp_cnt_o)
  );
endmodule

// File: rtl/disp_steer_chk.sv
module disp_steer_chk #(
  parameter int SLOTS  = 4,
  parameter int FREE_W = 6,
  parameter int CNT_W  = 16,
  localparam int CW    = $clog2(SLOTS + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SLOTS-1:0]  slot_valid_i,
  input logic [FREE_W-1:0] iq_free_i,
  input logic [SLOTS-1:0]  iq_wr_o,
  input logic [SLOTS-1:0]  lsq_ld_o,
  input logic [SLOTS-1:0]  lsq_st_o,
  input logic [SLOTS-1:0]  ns_wr_o,
  input logic [SLOTS-1:0]  tail_adv_o,
  input logic [SLOTS-1:0]  mark_issued_o,
  input logic [SLOTS-1:0]  mark_exec_o,
  input logic [SLOTS-1:0]  mark_commit_o,
  input logic [CW-1:0]     consumed_o,
  input logic              block_o,
  input logic [CNT_W-1:0]  full_cnt_o
);
  logic             started_q;
  logic [SLOTS-1:0] entry_use;

  assign entry_use = iq_wr_o | ns_wr_o | tail_adv_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else         started_q <= 1'b1;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_chk
    // R1
    idle_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !slot_valid_i[g] |-> !entry_use[g]);
    // R8
    one_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({iq_wr_o[g], ns_wr_o[g], tail_adv_o[g]}));
    // R4
    ld_in_iq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lsq_ld_o[g] |-> (iq_wr_o[g] && !lsq_st_o[g]));
    // R5
    st_in_iq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lsq_st_o[g] |-> iq_wr_o[g]);
    // R6
    ns_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ns_wr_o[g] |-> (mark_commit_o[g] && !mark_issued_o[g]));
    // R7
    nop_marks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tail_adv_o[g] |-> (mark_issued_o[g] && mark_exec_o[g] && mark_commit_o[g]));
  end

  // R3
  free_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(entry_use) <= int'(iq_free_i));
  // R3
  block_trunc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_o |-> (int'(consumed_o) < SLOTS));
  // R9
  consumed_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(entry_use) <= int'(consumed_o));
  // R3
  full_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |-> (full_cnt_o == $past(full_cnt_o) + CNT_W'($past(block_o))));
endmodule

bind disp_steer disp_steer_chk #(
  .SLOTS  (SLOTS),
  .FREE_W (FREE_W),
  .CNT_W  (CNT_W)
) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .slot_valid_i  (slot_valid_i),
  .iq_free_i     (iq_free_i),
  .iq_wr_o       (iq_wr_o),
  .lsq_ld_o      (lsq_ld_o),
  .lsq_st_o      (lsq_st_o),
  .ns_wr_o       (ns_wr_o),
  .tail_adv_o    (tail_adv_o),
  .mark_issued_o (mark_issued_o),
  .mark_exec_o   (mark_exec_o),
  .mark_commit_o (mark_commit_o),
  .consumed_o    (consumed_o),
  .block_o       (block_o),
  .full_cnt_o    (full_cnt_o)
);

// File: tb/disp_steer_tb_top.sv
`timescale 1ns/1ps
module disp_steer_tb_top;
  localparam int SLOTS  = 4;
  localparam int FREE_W = 6;
  localparam int CNT_W  = 16;
  localparam int NVEC   = 10;

  typedef struct packed {
    logic [3:0] v, sq, ld, st, ns, nop;
    logic [5:0] fr;
    logic [3:0] eiq, eld, est, ens, etl;
    logic [2:0] ec;
    logic       eb;
    logic [2:0] es;
  } vec_t;

  // fields: valid squash load store nspec nop | free | iq ld st ns tail | consumed block squashed
  localparam vec_t TBL [NVEC] = '{
    '{4'b1111,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,6'd4,4'b1111,4'b0000,4'b0000,4'b0000,4'b0000,3'd4,1'b0,3'd0},
    '{4'b1111,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,6'd2,4'b0011,4'b0000,4'b0000,4'b0000,4'b0000,3'd2,1'b1,3'd0},
    '{4'b0111,4'b0010,4'b0000,4'b0000,4'b0000,4'b0000,6'd1,4'b0001,4'b0000,4'b0000,4'b0000,4'b0000,3'd2,1'b1,3'd1},
    '{4'b1111,4'b0000,4'b0001,4'b0010,4'b0100,4'b1000,6'd4,4'b0011,4'b0001,4'b0010,4'b0100,4'b1000,3'd4,1'b0,3'd0},
    '{4'b1011,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,6'd4,4'b0011,4'b0000,4'b0000,4'b0000,4'b0000,3'd2,1'b0,3'd0},
    '{4'b0001,4'b0000,4'b0001,4'b0001,4'b0001,4'b0001,6'd4,4'b0001,4'b0001,4'b0000,4'b0000,4'b0000,3'd1,1'b0,3'd0},
    '{4'b0011,4'b0001,4'b0011,4'b0000,4'b0000,4'b0000,6'd0,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,3'd1,1'b1,3'd1},
    '{4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,6'd0,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,3'd0,1'b0,3'd0},
    '{4'b0011,4'b0000,4'b0000,4'b0001,4'b0011,4'b0000,6'd7,4'b0001,4'b0000,4'b0001,4'b0010,4'b0000,3'd2,1'b0,3'd0},
    '{4'b0011,4'b0000,4'b0000,4'b0000,4'b0001,4'b0011,6'd4,4'b0000,4'b0000,4'b0000,4'b0001,4'b0010,3'd2,1'b0,3'd0}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [SLOTS-1:0] slot_valid_i = '0, slot_squash_i = '0, slot_load_i = '0;
  logic [SLOTS-1:0] slot_store_i = '0, slot_nspec_i = '0, slot_nop_i = '0;
  logic [FREE_W-1:0] iq_free_i = '0;
  logic [SLOTS-1:0] iq_wr_o, lsq_ld_o, lsq_st_o, ns_wr_o, tail_adv_o;
  logic [SLOTS-1:0] mark_issued_o, mark_exec_o, mark_commit_o;
  logic [2:0] consumed_o;
  logic block_o;
  logic [CNT_W-1:0] sq_cnt_o, full_cnt_o, ld_cnt_o, st_cnt_o, ns_cnt_o, disp_cnt_o;

  int checks = 0;
  int errors = 0;
  int a_sq = 0, a_full = 0, a_ld = 0, a_st = 0, a_ns = 0, a_disp = 0;

  always #4 clk_i = ~clk_i;

  disp_steer #(.SLOTS(SLOTS), .FREE_W(FREE_W), .CNT_W(CNT_W)) dut_i (.*);

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic chk_counters();
    chk("R2 sq_cnt",   32'(sq_cnt_o),   32'(a_sq));
    chk("R3 full_cnt", 32'(full_cnt_o), 32'(a_full));
    chk("R4 ld_cnt",   32'(ld_cnt_o),   32'(a_ld));
    chk("R5 st_cnt",   32'(st_cnt_o),   32'(a_st));
    chk("R6 ns_cnt",   32'(ns_cnt_o),   32'(a_ns));
    chk("R8 disp_cnt", 32'(disp_cnt_o), 32'(a_disp));
  endtask

  task automatic drive_idle();
    slot_valid_i = '0; slot_squash_i = '0; slot_load_i = '0;
    slot_store_i = '0; slot_nspec_i = '0; slot_nop_i = '0;
    iq_free_i = '0;
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    // R10 reset state
    chk_counters();
    chk("R10 idle strobes", 32'(iq_wr_o | ns_wr_o | tail_adv_o), 32'h0);
    chk("R10 idle consumed", 32'(consumed_o), 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk_i);
      slot_valid_i = TBL[k].v;  slot_squash_i = TBL[k].sq;
      slot_load_i  = TBL[k].ld; slot_store_i  = TBL[k].st;
      slot_nspec_i = TBL[k].ns; slot_nop_i    = TBL[k].nop;
      iq_free_i    = TBL[k].fr;
      #1;
      chk($sformatf("R1/R8 v%0d iq_wr", k),      32'(iq_wr_o),       32'(TBL[k].eiq));
      chk($sformatf("R4 v%0d lsq_ld", k),        32'(lsq_ld_o),      32'(TBL[k].eld));
      chk($sformatf("R5 v%0d lsq_st", k),        32'(lsq_st_o),      32'(TBL[k].est));
      chk($sformatf("R6 v%0d ns_wr", k),         32'(ns_wr_o),       32'(TBL[k].ens));
      chk($sformatf("R7 v%0d tail_adv", k),      32'(tail_adv_o),    32'(TBL[k].etl));
      chk($sformatf("R7 v%0d issued", k),        32'(mark_issued_o), 32'(TBL[k].etl));
      chk($sformatf("R7 v%0d exec", k),          32'(mark_exec_o),   32'(TBL[k].etl));
      chk($sformatf("R6 v%0d commit", k),        32'(mark_commit_o), 32'(TBL[k].etl | TBL[k].ens));
      chk($sformatf("R9 v%0d consumed", k),      32'(consumed_o),    32'(TBL[k].ec));
      chk($sformatf("R3 v%0d block", k),         32'(block_o),       32'(TBL[k].eb));
      a_sq   += int'(TBL[k].es);
      a_full += int'(TBL[k].eb);
      a_ld   += $countones(TBL[k].eld);
      a_st   += $countones(TBL[k].est);
      a_ns   += $countones(TBL[k].ens);
      a_disp += $countones(TBL[k].eiq) - $countones(TBL[k].eld) - $countones(TBL[k].est);
      @(posedge clk_i);
      #1;
      chk_counters();
    end

    // R1: gap at slot 0 hides all later valid slots even with free entries
    @(negedge clk_i);
    drive_idle();
    slot_valid_i = 4'b1110; iq_free_i = 6'd4;
    #1;
    chk("R1 gap strobes", 32'(iq_wr_o | ns_wr_o | tail_adv_o), 32'h0);
    chk("R1 gap consumed", 32'(consumed_o), 32'h0);

    // R2: fully squashed group with no free entries consumes all, no block
    @(negedge clk_i);
    slot_valid_i = 4'b1111; slot_squash_i = 4'b1111; iq_free_i = 6'd0;
    #1;
    chk("R2 all squashed consumed", 32'(consumed_o), 32'd4);
    chk("R2 all squashed block", 32'(block_o), 32'd0);
    @(posedge clk_i);
    #1;
    a_sq += 4;
    chk("R2 sq_cnt after group", 32'(sq_cnt_o), 32'(a_sq));

    // R10: mid-run reset clears counters
    @(negedge clk_i);
    drive_idle();
    rst_ni = 1'b0;
    #1;
    a_sq = 0; a_full = 0; a_ld = 0; a_st = 0; a_ns = 0; a_disp = 0;
    chk_counters();
    @(negedge clk_i);
    rst_ni = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule